// File: doc/BRIEF.md
# Clock Policy Mask Engine

This block keeps a small table of clock masks, one per power policy, and turns the policy that is currently in force into a vector of per-clock run enables. Every clock keeps the same bit position in all of the masks. A set bit means that the clock runs while that policy is selected. A 2-bit input chooses the active policy. The enable vector is registered, so it follows the selected mask one cycle later.

Software reaches the block through a plain word-addressed register port. The port has one write strobe and a combinational read path. Every write is refused until a fixed key has been written to the access register at offset 0. Any other value written there takes write permission away again.

The mask table is edited as a shadow copy. The engine must first be halted through the configuration register, and only then are mask writes accepted. A mask write made while the engine runs is dropped and sets a sticky error flag. The edited table goes live through a GO command that names one of two restart modes. GO reads back as 1 while the load is in progress. Once the shadow table has been copied into the live table, GO clears and the engine runs again.

Top module: `clk_policy_ctrl`

## Requirements
- R1: After reset the block is locked and running, with no load pending. The error flag and the mode flag are 0, and all shadow masks, all live masks and `clk_en` are all ones.
- R2: While the engine runs, `clk_en` after each clock edge equals the live mask of the policy that `policy_sel` selected before that edge.
- R3: While the block is locked, a write to any address other than 0 has no effect on any register.
- R4: A write of the key 32'hC1A5_0E7B to address 0 unlocks the block, and a write of any other value to address 0 locks it. Reading address 0 returns the lock state in bit 0 (1 = unlocked).
- R5: An unlocked write to address 1 with bit 0 set halts the engine. A write with bit 0 clear has no effect. While the engine is halted, `clk_en` holds its value whatever `policy_sel` does. Address 1 bit 0 reads 1 while the engine is halted.
- R6: An unlocked write to mask address 4+p (p = 0..3) stores the data in shadow mask p only when the engine is halted and no load is pending. Otherwise the data is dropped and the sticky error flag (address 3 bit 0) is set. An unlocked write to address 3 with bit 0 set clears the flag.
- R7: An unlocked write to address 2 with bit 0 (GO) set and exactly one of bit 1 (ATL) and bit 2 (AC) set starts a load, but only while the engine is halted and no load is pending. Address 2 bit 0 then reads 1. LOAD_CYCLES edges after the write, every shadow mask is copied into the live table, GO reads 0 and the engine runs. Any other GO request is ignored.
- R8: Address 3 bit 2 reports the mode of the last accepted GO (1 = AC, 0 = ATL). Address 3 bit 1 reads 1 while the engine runs.
- R9: Reading address 4+p returns shadow mask p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 3 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| policy_sel | input | 2 | Active policy index |
| clk_en | output | 32 | Per-clock run enable |

## Verification
Register writes take effect at the edge that samples the strobe, and reads are combinational, so a readback is due in the same low phase that follows that edge. `clk_en` lags `policy_sel` and the live table by one edge. A GO command copies the table LOAD_CYCLES edges after its write, and `clk_en` shows the new masks one edge after that. The bench keeps a behavioural model that advances at each rising edge. It compares `clk_en` at every falling edge, and it compares each register read one time unit after a falling edge. Every result is therefore sampled after the edge it depends on and before the next one.

// File: rtl/ckp_pkg.sv
package ckp_pkg;

  localparam int REG_ACCESS  = 0;
  localparam int REG_CONFIG  = 1;
  localparam int REG_CONTROL = 2;
  localparam int REG_STATUS  = 3;
  localparam int MASK_BASE   = 4;

  // a restart request is well formed when GO is set with exactly one mode
  function automatic logic f_go_ok(input logic go, input logic atl, input logic ac);
    return go && (atl ^ ac);
  endfunction

  // address lies inside the mask window
  function automatic logic f_in_window(input int addr, input int base, input int n);
    return (addr >= base) && (addr < base + n);
  endfunction

endpackage

// File: rtl/ckp_gatekeeper.sv
module ckp_gatekeeper #(
  parameter int          DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = 32'hC1A5_0E7B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              open
);

  logic key_hit;
  assign key_hit = (wdata == KEY);

  always_ff @(posedge clk) begin
    if (rst)         open <= 1'b0;
    else if (acc_wr) open <= key_hit;
  end

  p_bad_key_locks_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && (wdata != KEY)) |=> !open);
  p_key_unlocks_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && (wdata == KEY)) |=> open);

endmodule

// File: rtl/ckp_sequencer.sv
module ckp_sequencer
  import ckp_pkg::*;
#(
  parameter int LOAD_CYCLES = 2,
  localparam int CNT_W = $clog2(LOAD_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic stop_wr,
  input  logic go_wr,
  input  logic go_bit,
  input  logic atl_bit,
  input  logic ac_bit,
  output logic stopped,
  output logic go_pend,
  output logic load_evt,
  output logic mode_ac
);

  logic [CNT_W-1:0] cnt;
  logic             go_accept;

  assign go_accept = go_wr && f_go_ok(go_bit, atl_bit, ac_bit) && stopped && !go_pend;
  assign load_evt  = go_pend && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      stopped <= 1'b0;
      go_pend <= 1'b0;
      cnt     <= '0;
      mode_ac <= 1'b0;
    end else if (load_evt) begin
      stopped <= 1'b0;
      go_pend <= 1'b0;
      cnt     <= '0;
    end else begin
      if (stop_wr && !stopped) stopped <= 1'b1;
      if (go_accept) begin
        go_pend <= 1'b1;
        cnt     <= CNT_W'(LOAD_CYCLES);
        mode_ac <= ac_bit;
      end else if (go_pend) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  p_go_needs_halt_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(go_pend) |-> $past(stopped));
  p_load_restarts_r7: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> (!stopped && !go_pend));
  p_pend_implies_halt_r7: assert property (@(posedge clk) disable iff (rst)
    go_pend |-> stopped);

endmodule

// File: rtl/ckp_mask_bank.sv
module ckp_mask_bank #(
  parameter int NUM_POL = 4,
  parameter int NUM_CLK = 32,
  localparam int POL_W = $clog2(NUM_POL)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_POL-1:0]              wr_sel,
  input  logic [NUM_CLK-1:0]              wdata,
  input  logic                            load_evt,
  input  logic                            run,
  input  logic [POL_W-1:0]                pol_sel,
  output logic [NUM_POL-1:0][NUM_CLK-1:0] shadow,
  output logic [NUM_CLK-1:0]              clk_en
);

  logic [NUM_POL-1:0][NUM_CLK-1:0] live;

  for (genvar p = 0; p < NUM_POL; p++) begin : g_pol
    always_ff @(posedge clk) begin
      if (rst)            shadow[p] <= '1;
      else if (wr_sel[p]) shadow[p] <= wdata;
    end
    always_ff @(posedge clk) begin
      if (rst)           live[p] <= '1;
      else if (load_evt) live[p] <= shadow[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      clk_en <= '1;
    else if (run) clk_en <= live[pol_sel];
  end

  p_hold_when_halted_r5: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(clk_en));
  p_shadow_only_by_write_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_sel == '0) |=> $stable(shadow));
  p_one_target_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel));

endmodule

// File: rtl/clk_policy_ctrl.sv
module clk_policy_ctrl
  import ckp_pkg::*;
#(
  parameter int                 NUM_POL     = 4,
  parameter int                 NUM_CLK     = 32,
  parameter logic [NUM_CLK-1:0] KEY         = 32'hC1A5_0E7B,
  parameter int                 LOAD_CYCLES = 2,
  localparam int POL_W  = $clog2(NUM_POL),
  localparam int ADDR_W = $clog2(MASK_BASE + NUM_POL)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_CLK-1:0] bus_wdata,
  output logic [NUM_CLK-1:0] bus_rdata,
  input  logic [POL_W-1:0]   policy_sel,
  output logic [NUM_CLK-1:0] clk_en
);

  logic                            open;
  logic                            stopped, go_pend, load_evt, mode_ac;
  logic                            wr_ok;
  logic                            is_mask;
  logic [POL_W-1:0]                mask_idx;
  logic                            mask_try, mask_allowed;
  logic [NUM_POL-1:0]              shadow_we;
  logic                            err_q, err_set, err_clr;
  logic [NUM_POL-1:0][NUM_CLK-1:0] shadow;

  assign wr_ok    = bus_wr && open && (bus_addr != ADDR_W'(REG_ACCESS));
  assign is_mask  = f_in_window(int'(bus_addr), MASK_BASE, NUM_POL);
  assign mask_idx = POL_W'(bus_addr - ADDR_W'(MASK_BASE));

  assign mask_try     = wr_ok && is_mask;
  assign mask_allowed = stopped && !go_pend;
  assign err_set      = mask_try && !mask_allowed;
  assign err_clr      = wr_ok && (bus_addr == ADDR_W'(REG_STATUS)) && bus_wdata[0];

  for (genvar p = 0; p < NUM_POL; p++) begin : g_we
    assign shadow_we[p] = mask_try && mask_allowed && (mask_idx == POL_W'(p));
  end

  ckp_gatekeeper #(.DATA_W(NUM_CLK), .KEY(KEY)) u_gate (
    .clk    (clk),
    .rst    (rst),
    .acc_wr (bus_wr && (bus_addr == ADDR_W'(REG_ACCESS))),
    .wdata  (bus_wdata),
    .open   (open)
  );

  ckp_sequencer #(.LOAD_CYCLES(LOAD_CYCLES)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .stop_wr  (wr_ok && (bus_addr == ADDR_W'(REG_CONFIG)) && bus_wdata[0]),
    .go_wr    (wr_ok && (bus_addr == ADDR_W'(REG_CONTROL))),
    .go_bit   (bus_wdata[0]),
    .atl_bit  (bus_wdata[1]),
    .ac_bit   (bus_wdata[2]),
    .stopped  (stopped),
    .go_pend  (go_pend),
    .load_evt (load_evt),
    .mode_ac  (mode_ac)
  );

  ckp_mask_bank #(.NUM_POL(NUM_POL), .NUM_CLK(NUM_CLK)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_sel   (shadow_we),
    .wdata    (bus_wdata),
    .load_evt (load_evt),
    .run      (!stopped),
    .pol_sel  (policy_sel),
    .shadow   (shadow),
    .clk_en   (clk_en)
  );

  always_ff @(posedge clk) begin
    if (rst)          err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
    else if (err_clr) err_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    if (is_mask) bus_rdata = shadow[mask_idx];
    else begin
      case (int'(bus_addr))
        REG_ACCESS:  bus_rdata[0]   = open;
        REG_CONFIG:  bus_rdata[0]   = stopped;
        REG_CONTROL: bus_rdata[0]   = go_pend;
        REG_STATUS:  bus_rdata[2:0] = {mode_ac, !stopped, err_q};
        default:     bus_rdata      = '0;
      endcase
    end
  end

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (err_q && !err_clr) |=> err_q);
  p_locked_no_mask_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !open) |=> $stable(shadow));
  p_locked_no_halt_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !open && !stopped) |=> !stopped);

endmodule

// File: tb/clk_policy_ctrl_tb_top.sv
module clk_policy_ctrl_tb_top;

  localparam logic [31:0] KEY  = 32'hC1A5_0E7B;
  localparam int          LOAD = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  policy_sel = '0;
  logic [31:0] clk_en;

  int total = 0, bad = 0, cyc_total = 0, cyc_bad = 0;

  always #4 clk = ~clk;

  clk_policy_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .policy_sel(policy_sel), .clk_en(clk_en)
  );

  // behavioural reference
  logic        m_open, m_stop, m_pend, m_ac, m_err;
  int          m_cnt;
  logic [31:0] m_sh [4];
  logic [31:0] m_act[4];
  logic [31:0] m_clk;

  task automatic model_reset();
    m_open = 0; m_stop = 0; m_pend = 0; m_ac = 0; m_err = 0; m_cnt = 0;
    for (int i = 0; i < 4; i++) begin m_sh[i] = '1; m_act[i] = '1; end
    m_clk = '1;
  endtask

  initial model_reset();

  always @(posedge clk) begin : mdl
    logic n_open, n_stop, n_pend, n_ac, n_err, load;
    int n_cnt;
    if (rst) model_reset();
    else begin
      n_open = m_open; n_stop = m_stop; n_pend = m_pend; n_ac = m_ac;
      n_err = m_err; n_cnt = m_cnt;
      load = m_pend && (m_cnt == 1);
      if (!m_stop) m_clk = m_act[policy_sel];
      if (bus_wr) begin
        if (bus_addr == 0) n_open = (bus_wdata == KEY);
        else if (m_open) begin
          case (bus_addr)
            3'd1: if (bus_wdata[0]) n_stop = 1;
            3'd2: if (m_stop && !m_pend && bus_wdata[0] && (bus_wdata[1] != bus_wdata[2])) begin
                    n_pend = 1; n_cnt = LOAD; n_ac = bus_wdata[2];
                  end
            3'd3: if (bus_wdata[0]) n_err = 0;
            default: if (m_stop && !m_pend) m_sh[bus_addr - 4] = bus_wdata;
                     else n_err = 1;
          endcase
        end
      end
      if (load) begin
        for (int i = 0; i < 4; i++) m_act[i] = m_sh[i];
        n_stop = 0; n_pend = 0; n_cnt = 0;
      end else if (m_pend) n_cnt = m_cnt - 1;
      m_open = n_open; m_stop = n_stop; m_pend = n_pend; m_ac = n_ac;
      m_err = n_err; m_cnt = n_cnt;
    end
  end

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {31'd0, m_open};
      3'd1: return {31'd0, m_stop};
      3'd2: return {31'd0, m_pend};
      3'd3: return {29'd0, m_ac, !m_stop, m_err};
      default: return m_sh[a - 4];
    endcase
  endfunction

  // clk_en compared with the model at every falling edge (R2, R5)
  always @(negedge clk) begin
    if (!rst) begin
      cyc_total++;
      if (clk_en !== m_clk) begin
        cyc_bad++;
        $display("FAIL %s clk_en act=%h exp=%h", m_stop ? "R5" : "R2", clk_en, m_clk);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    @(negedge clk);
    bus_wr = 0; bus_addr = a;
    #1;
    total++;
    if (bus_rdata !== model_read(a)) begin
      bad++;
      $display("FAIL %s addr=%0d act=%h exp=%h", tag, a, bus_rdata, model_read(a));
    end
  endtask

  task automatic rd_fixed(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_wr = 0; bus_addr = a;
    #1;
    total++;
    if (bus_rdata !== exp) begin
      bad++;
      $display("FAIL %s addr=%0d act=%h exp=%h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sweep_pol();
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); policy_sel = 2'(p);
      idle(2);
    end
  endtask

  initial begin : watchdog
    #(8 * 100000);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total + cyc_total, bad + cyc_bad);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk) rst = 0;
    // R1: reset state
    for (int a = 0; a < 8; a++) rd(3'(a), "R1");
    rd_fixed(3'd3, 32'h2, "R1");
    rd_fixed(3'd4, 32'hFFFF_FFFF, "R1");
    // R3: locked writes ignored
    wr(3'd4, 32'h1234_5678);
    wr(3'd1, 32'h1);
    rd_fixed(3'd4, 32'hFFFF_FFFF, "R3");
    rd_fixed(3'd1, 32'h0, "R3");
    rd_fixed(3'd3, 32'h2, "R3");
    // R4: wrong key stays locked, right key unlocks
    wr(3'd0, KEY ^ 32'h1);
    rd_fixed(3'd0, 32'h0, "R4");
    wr(3'd0, KEY);
    rd_fixed(3'd0, 32'h1, "R4");
    // R6: mask write while running is dropped, error set and cleared
    wr(3'd5, 32'h0000_00F0);
    rd_fixed(3'd5, 32'hFFFF_FFFF, "R6");
    rd_fixed(3'd3, 32'h3, "R6");
    wr(3'd3, 32'h1);
    rd_fixed(3'd3, 32'h2, "R6");
    // R7: GO while running ignored
    wr(3'd2, 32'h5);
    rd_fixed(3'd2, 32'h0, "R7");
    // R5: clearing write has no effect, setting write halts
    wr(3'd1, 32'h0);
    rd_fixed(3'd1, 32'h0, "R5");
    wr(3'd1, 32'h1);
    rd_fixed(3'd1, 32'h1, "R5");
    sweep_pol();
    // R9: shadow masks written and read back
    wr(3'd4, 32'hA5A5_0001);
    wr(3'd5, 32'h0F0F_0F0F);
    wr(3'd6, 32'h0000_0000);
    wr(3'd7, 32'h8000_FFFF);
    for (int a = 4; a < 8; a++) rd(3'(a), "R9");
    rd_fixed(3'd6, 32'h0, "R9");
    // R8/R7: malformed GO requests ignored
    wr(3'd2, 32'h7);
    rd_fixed(3'd2, 32'h0, "R7");
    wr(3'd2, 32'h1);
    rd_fixed(3'd2, 32'h0, "R8");
    wr(3'd2, 32'h6);
    rd_fixed(3'd2, 32'h0, "R7");
    // R7: GO with AC, pending readback, mask write during load rejected (R6)
    @(negedge clk);
    bus_wr = 1; bus_addr = 3'd2; bus_wdata = 32'h5;
    @(negedge clk);
    bus_wr = 0; bus_addr = 3'd2;
    #1; total++;
    if (bus_rdata !== 32'h1) begin bad++; $display("FAIL R7 pending act=%h exp=%h", bus_rdata, 32'h1); end
    wr(3'd4, 32'hDEAD_BEEF);
    rd(3'd3, "R6");
    rd(3'd4, "R6");
    idle(3);
    rd_fixed(3'd2, 32'h0, "R7");
    rd_fixed(3'd3, 32'h7, "R8");
    wr(3'd3, 32'h1);
    sweep_pol();
    // R8: restart with ATL
    wr(3'd1, 32'h1);
    wr(3'd7, 32'h1111_2222);
    wr(3'd2, 32'h3);
    idle(4);
    rd_fixed(3'd3, 32'h2, "R8");
    sweep_pol();
    // R4/R3: relock, then writes have no effect
    wr(3'd0, 32'h0);
    rd_fixed(3'd0, 32'h0, "R4");
    wr(3'd1, 32'h1);
    rd_fixed(3'd1, 32'h0, "R3");
    sweep_pol();
    $display("  test done: total=%0d bad=%0d", total + cyc_total, bad + cyc_bad);
    $finish;
  end

endmodule